// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

The sequencer takes single read or write requests from an internal master and plays each one out on an external memory bus as a string of one-clock phases. Every access first drives the address. It can then add internal wait states and one data phase. Reads may run a burst of further beats, with an optional wait before each beat. Writes may take an early-write trailing phase. Hold phases and idle phases can follow. For zones set to fast reads, a read is a single phase instead. Each zone has its own settings for wait count, hold count, burst wait, early write, fast read and a pause before and after the zone. The settings are given as packed vectors with one slice per zone.

A request is taken on a valid/ready handshake. It carries an address, a write flag, write data, byte enables, a zone number and a burst length. The sequencer lowers ready until the current bus cycle has finished and the required idle gap has passed. Read data is captured at the end of each sampling phase and comes back one clock later, with a one-cycle valid pulse for each beat. Between accesses all strobes stay low and the data output enable stays off.

Top module: `xbus_cycle_seq`

## Requirements
- R1: Each access that is not a fast read starts with an address phase. In that phase the address is driven, the zone select is on (bit `req_zone` of `bus_sel`), and neither the data output enable nor the write strobes are on. `bus_sel` is never active on more than one bit.
- R2: A normal read has an address phase, waits, then one data phase with select and `bus_rd` high. Bus data is captured at the end of the data phase. It appears on `rd_data` with `rd_valid` high for exactly the next cycle.
- R3: In a write data phase, `bus_doe` is on and `bus_we` equals the byte enables. `bus_rd` and `bus_we` are never active together.
- R4: In a fast-read zone, a read uses a single phase with address, select and `bus_rd` all active, and data is captured at its end. No wait states are added.
- R5: In an early-write zone, the data phase is followed by one trailing phase. In it the select is off, `bus_we` still carries the byte enables, and address, write data and `bus_doe` stay valid.
- R6: The zone's wait count (0 to 7) sets how many wait phases come between the address phase and the data phase. For writes, the wait phases drive data with `bus_doe` and `bus_we` on.
- R7: A read with burst length field L runs L extra beats after the first data (or fast) phase. Each beat captures data, and the address rises by one for each beat.
- R8: If burst wait is on for the zone, one wait phase (select and `bus_rd` on, no capture) comes before each extra beat. The address advances at the start of that wait phase.
- R9: The zone's hold count (0 to 7) sets how many hold phases follow the last data, burst or trailing phase. During hold, select and strobes are off, the address holds, and for writes `bus_doe` and the data stay on. `bus_doe` drops after the final hold phase, or right after the last phase when the hold count is zero.
- R10: When no request is in flight, `req_ready` depends only on the idle gap rule, and select, `bus_rd`, `bus_we` and `bus_doe` are all low. Out of reset, `req_ready` is high. At least one idle cycle separates two accesses.
- R11: An early write followed by any read, or a late write followed by a fast read, needs at least 2 cycles of hold plus idle in between.
- R12: When the zone changes from one access to the next, hold plus idle must be at least the larger of the old zone's post pause and the new zone's pre pause. Hold phases count toward every gap rule, so the rules merge and do not add. The idle count is max(1, required − previous hold).
- R13: For writes the burst length is ignored: no burst beat or burst wait phase ever follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables for writes |
| req_zone | input | ZW | Target zone index |
| req_len | input | LW | Extra read burst beats |
| cfg_wait | input | NZ*CW | Wait count per zone |
| cfg_hold | input | NZ*CW | Hold count per zone |
| cfg_pre | input | NZ*CW | Pause before entering a zone |
| cfg_post | input | NZ*CW | Pause after leaving a zone |
| cfg_bwait | input | NZ | Burst wait enable per zone |
| cfg_early | input | NZ | Early-write mode per zone |
| cfg_fast | input | NZ | Fast-read mode per zone |
| bus_addr | output | AW | External address |
| bus_wdata | output | DW | External write data |
| bus_doe | output | 1 | Data output enable (low = tri-state) |
| bus_rdata | input | DW | External read data |
| bus_sel | output | NZ | Zone selects, active high |
| bus_rd | output | 1 | Read strobe |
| bus_we | output | DW/8 | Byte write strobes |
| rd_valid | output | 1 | Read beat returned |
| rd_data | output | DW | Returned read data |

## Verification
The assertions assume that the zone settings only change while the sequencer is idle. They also assume that `req_zone` names an existing zone and that a request is held steady until it is taken. The stimulus changes the settings only between accesses, while the handshake is idle. It draws zones only from the valid range, and it keeps every field of a request steady from the time it raises valid until the accept edge. Back-to-back requests are offered in the first idle cycle, so the exact gap length is observed.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
    typedef enum logic [3:0] {
        PH_IDLE, PH_ADDR, PH_WAIT, PH_DATA, PH_FAST,
        PH_TRAIL, PH_BWAIT, PH_BDATA, PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        KD_READ, KD_FAST, KD_LATE_WR, KD_EARLY_WR
    } kind_e;
endpackage

// File: rtl/xbus_gap_check.sv
`timescale 1ns/1ps
module xbus_gap_check
    import xbus_pkg::*;
#(
    parameter int CW = 3,
    parameter int ZW = 1
) (
    input  logic          have_last,
    input  kind_e         last_kind,
    input  logic [ZW-1:0] last_zone,
    input  logic [CW-1:0] last_post,
    input  logic [CW-1:0] last_hold,
    input  kind_e         new_kind,
    input  logic [ZW-1:0] new_zone,
    input  logic [CW-1:0] new_pre,
    input  logic [CW:0]   idle_seen,
    output logic          gap_ok
);
    localparam int TW = CW + 2;

    logic          pair_hit;
    logic          zone_hit;
    logic [CW-1:0] zone_need;
    logic [TW-1:0] need;
    logic [TW-1:0] spent;

    always_comb begin
        pair_hit = have_last &&
                   ((last_kind == KD_EARLY_WR &&
                     (new_kind == KD_READ || new_kind == KD_FAST)) ||
                    (last_kind == KD_LATE_WR && new_kind == KD_FAST));
        zone_hit  = have_last && (last_zone != new_zone);
        zone_need = (new_pre > last_post) ? new_pre : last_post;
        need = '0;
        if (pair_hit) need = TW'(2);
        if (zone_hit && TW'(zone_need) > need) need = TW'(zone_need);
        // hold cycles already spent count toward the gap (merge, not add)
        spent  = TW'(idle_seen) + TW'(1) + TW'(last_hold);
        gap_ok = (spent >= need);
    end
endmodule

// File: rtl/xbus_pin_decode.sv
`timescale 1ns/1ps
module xbus_pin_decode
    import xbus_pkg::*;
#(
    parameter int NZ  = 2,
    parameter int ZW  = 1,
    parameter int BEW = 2
) (
    input  phase_e         ph,
    input  kind_e          kind,
    input  logic [ZW-1:0]  zone,
    input  logic [BEW-1:0] be,
    output logic [NZ-1:0]  sel,
    output logic           rd,
    output logic [BEW-1:0] we,
    output logic           doe
);
    logic is_wr;
    logic sel_act;
    logic we_act;

    always_comb begin
        is_wr   = (kind == KD_LATE_WR) || (kind == KD_EARLY_WR);
        sel_act = (ph == PH_ADDR) || (ph == PH_WAIT) || (ph == PH_DATA) ||
                  (ph == PH_FAST) || (ph == PH_BWAIT) || (ph == PH_BDATA);
        rd      = !is_wr && sel_act && (ph != PH_ADDR);
        we_act  = is_wr && ((ph == PH_WAIT) || (ph == PH_DATA) ||
                            (kind == KD_EARLY_WR && ph == PH_TRAIL));
        we      = we_act ? be : '0;
        doe     = is_wr && ((ph == PH_WAIT) || (ph == PH_DATA) ||
                            (ph == PH_TRAIL) || (ph == PH_HOLD));
    end

    for (genvar z = 0; z < NZ; z++) begin : g_sel
        assign sel[z] = sel_act && (zone == ZW'(z));
    end
endmodule

// File: rtl/xbus_cycle_seq.sv
`timescale 1ns/1ps
module xbus_cycle_seq
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int NZ = 2,
    parameter int CW = 3,
    parameter int LW = 2,
    localparam int BEW = DW / 8,
    localparam int ZW  = (NZ > 1) ? $clog2(NZ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_wr,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [BEW-1:0]   req_be,
    input  logic [ZW-1:0]    req_zone,
    input  logic [LW-1:0]    req_len,
    input  logic [NZ*CW-1:0] cfg_wait,
    input  logic [NZ*CW-1:0] cfg_hold,
    input  logic [NZ*CW-1:0] cfg_pre,
    input  logic [NZ*CW-1:0] cfg_post,
    input  logic [NZ-1:0]    cfg_bwait,
    input  logic [NZ-1:0]    cfg_early,
    input  logic [NZ-1:0]    cfg_fast,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             bus_doe,
    input  logic [DW-1:0]    bus_rdata,
    output logic [NZ-1:0]    bus_sel,
    output logic             bus_rd,
    output logic [BEW-1:0]   bus_we,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    typedef struct packed {
        phase_e         ph;
        kind_e          kind;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [BEW-1:0] be;
        logic [ZW-1:0]  zone;
        logic [LW-1:0]  left;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  hold;
        logic           bw;
        logic [CW-1:0]  post;
        logic           have_last;
        logic [CW:0]    idle;
        logic           rv;
        logic [DW-1:0]  rdata;
    } st_t;

    localparam st_t ST_RST = '0;

    st_t   st_q, st_d;
    kind_e new_kind;
    logic  gap_ok;
    logic  is_rd_q;
    logic  accept;

    always_comb begin
        if (req_wr) new_kind = cfg_early[req_zone] ? KD_EARLY_WR : KD_LATE_WR;
        else        new_kind = cfg_fast[req_zone]  ? KD_FAST     : KD_READ;
    end

    xbus_gap_check #(.CW(CW), .ZW(ZW)) u_gap (
        .have_last (st_q.have_last),
        .last_kind (st_q.kind),
        .last_zone (st_q.zone),
        .last_post (st_q.post),
        .last_hold (st_q.hold),
        .new_kind  (new_kind),
        .new_zone  (req_zone),
        .new_pre   (cfg_pre[req_zone*CW +: CW]),
        .idle_seen (st_q.idle),
        .gap_ok    (gap_ok)
    );

    assign req_ready = (st_q.ph == PH_IDLE) && gap_ok;
    assign accept    = req_valid && req_ready;
    assign is_rd_q   = (st_q.kind == KD_READ) || (st_q.kind == KD_FAST);

    always_comb begin
        logic finish;
        st_d   = st_q;
        st_d.rv = 1'b0;
        finish = 1'b0;

        if (is_rd_q && (st_q.ph == PH_DATA || st_q.ph == PH_FAST ||
                        st_q.ph == PH_BDATA)) begin
            st_d.rv    = 1'b1;
            st_d.rdata = bus_rdata;
        end

        case (st_q.ph)
            PH_IDLE: begin
                if (st_q.idle != '1) st_d.idle = st_q.idle + 1'b1;
                if (accept) begin
                    st_d.kind      = new_kind;
                    st_d.addr      = req_addr;
                    st_d.wdata     = req_wdata;
                    st_d.be        = req_be;
                    st_d.zone      = req_zone;
                    st_d.left      = req_wr ? '0 : req_len;
                    st_d.cnt       = cfg_wait[req_zone*CW +: CW];
                    st_d.hold      = cfg_hold[req_zone*CW +: CW];
                    st_d.post      = cfg_post[req_zone*CW +: CW];
                    st_d.bw        = cfg_bwait[req_zone];
                    st_d.have_last = 1'b1;
                    st_d.ph        = (new_kind == KD_FAST) ? PH_FAST : PH_ADDR;
                end
            end
            PH_ADDR: begin
                if (st_q.cnt != '0) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.ph = PH_DATA;
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == '0) st_d.ph = PH_DATA;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_DATA, PH_FAST, PH_BDATA: begin
                if (is_rd_q) begin
                    if (st_q.left != '0) begin
                        st_d.left = st_q.left - 1'b1;
                        st_d.addr = st_q.addr + 1'b1;
                        st_d.ph   = st_q.bw ? PH_BWAIT : PH_BDATA;
                    end else begin
                        finish = 1'b1;
                    end
                end else if (st_q.kind == KD_EARLY_WR) begin
                    st_d.ph = PH_TRAIL;
                end else begin
                    finish = 1'b1;
                end
            end
            PH_BWAIT: st_d.ph = PH_BDATA;
            PH_TRAIL: finish = 1'b1;
            PH_HOLD: begin
                if (st_q.cnt == '0) begin
                    st_d.ph   = PH_IDLE;
                    st_d.idle = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase

        if (finish) begin
            if (st_q.hold != '0) begin
                st_d.ph  = PH_HOLD;
                st_d.cnt = st_q.hold - 1'b1;
            end else begin
                st_d.ph   = PH_IDLE;
                st_d.idle = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    xbus_pin_decode #(.NZ(NZ), .ZW(ZW), .BEW(BEW)) u_pins (
        .ph   (st_q.ph),
        .kind (st_q.kind),
        .zone (st_q.zone),
        .be   (st_q.be),
        .sel  (bus_sel),
        .rd   (bus_rd),
        .we   (bus_we),
        .doe  (bus_doe)
    );

    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign rd_valid  = st_q.rv;
    assign rd_data   = st_q.rdata;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel)); // R1
    AST_DOE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> $past(bus_sel != '0)); // R1
    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd)); // R2
    AST_NO_RD_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_we != '0)); // R3
    AST_WR_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_addr)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_sel == '0 && !bus_rd && bus_we == '0 && !bus_doe)); // R10
endmodule

// File: tb/xbus_cycle_seq_bench.sv
`timescale 1ns/1ps
module xbus_cycle_seq_bench;
    localparam int AW = 16, DW = 16, NZ = 2, CW = 3, LW = 2;
    localparam int BEW = DW / 8, ZW = 1;
    localparam int P_ADDR = 1, P_WAIT = 2, P_DATA = 3, P_FAST = 4,
                   P_TRAIL = 5, P_BWAIT = 6, P_BDATA = 7, P_HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0, req_ready, req_wr = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [DW-1:0]    req_wdata = '0;
    logic [BEW-1:0]   req_be = '0;
    logic [ZW-1:0]    req_zone = '0;
    logic [LW-1:0]    req_len = '0;
    logic [NZ*CW-1:0] cfg_wait = '0, cfg_hold = '0, cfg_pre = '0, cfg_post = '0;
    logic [NZ-1:0]    cfg_bwait = '0, cfg_early = '0, cfg_fast = '0;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_wdata, bus_rdata, rd_data;
    logic             bus_doe, bus_rd, rd_valid;
    logic [NZ-1:0]    bus_sel;
    logic [BEW-1:0]   bus_we;

    function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
        logic [DW-1:0] t;
        t = DW'(a) * DW'(3);
        return t ^ 16'h5A5A;
    endfunction

    assign bus_rdata = mem_of(bus_addr);

    xbus_cycle_seq #(.AW(AW), .DW(DW), .NZ(NZ), .CW(CW), .LW(LW)) u_xbus_cycle_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_addr, .req_wdata,
        .req_be, .req_zone, .req_len, .cfg_wait, .cfg_hold, .cfg_pre, .cfg_post,
        .cfg_bwait, .cfg_early, .cfg_fast, .bus_addr, .bus_wdata, .bus_doe,
        .bus_rdata, .bus_sel, .bus_rd, .bus_we, .rd_valid, .rd_data
    );

    int checks = 0, errors = 0;
    int zw[NZ], zh[NZ], zp[NZ], zq[NZ];
    bit zb[NZ], ze[NZ], zf[NZ];
    bit pend_rv = 0;
    logic [DW-1:0] pend_data = '0;
    bit last_v = 0;
    int last_kind = 0, last_zone = 0, last_post = 0, last_hold = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic set_zone(input int z, input int w, input int h, input int p, input int q,
                            input bit b, input bit e, input bit f);
        zw[z] = w; zh[z] = h; zp[z] = p; zq[z] = q; zb[z] = b; ze[z] = e; zf[z] = f;
        cfg_wait[z*CW +: CW] = CW'(w);
        cfg_hold[z*CW +: CW] = CW'(h);
        cfg_pre[z*CW +: CW]  = CW'(p);
        cfg_post[z*CW +: CW] = CW'(q);
        cfg_bwait[z] = b; cfg_early[z] = e; cfg_fast[z] = f;
    endtask

    task automatic check_rv();
        chk("R2", "rd_valid", rd_valid, pend_rv);
        if (pend_rv) chk("R2", "rd_data", rd_data, pend_data);
    endtask

    task automatic phase(input int ph, input bit wr, input bit early, input int zone,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [BEW-1:0] be, input string tag);
        bit sel_on, smp;
        @(negedge clk);
        sel_on = (ph == P_ADDR || ph == P_WAIT || ph == P_DATA || ph == P_FAST ||
                  ph == P_BWAIT || ph == P_BDATA);
        smp = !wr && (ph == P_DATA || ph == P_FAST || ph == P_BDATA);
        check_rv();
        chk(tag, "bus_sel", bus_sel, sel_on ? (1 << zone) : 0);
        chk(tag, "bus_rd", bus_rd, !wr && sel_on && ph != P_ADDR);
        chk(tag, "bus_we", bus_we,
            (wr && (ph == P_WAIT || ph == P_DATA || (early && ph == P_TRAIL))) ? be : 0);
        chk(tag, "bus_doe", bus_doe,
            wr && (ph == P_WAIT || ph == P_DATA || ph == P_TRAIL || ph == P_HOLD));
        chk(tag, "bus_addr", bus_addr, a);
        if (bus_doe) chk(tag, "bus_wdata", bus_wdata, wd);
        pend_rv = smp;
        pend_data = mem_of(a);
    endtask

    task automatic do_txn(input bit wr, input int zone, input logic [AW-1:0] addr,
                          input int len, input logic [DW-1:0] wd, input logic [BEW-1:0] be);
        int kind, need, exp_idle, idles;
        string gtag;
        logic [AW-1:0] a;
        bit wtag;
        kind = wr ? (ze[zone] ? 3 : 2) : (zf[zone] ? 1 : 0);
        need = 0; gtag = "R10";
        if (last_v && ((last_kind == 3 && kind <= 1) || (last_kind == 2 && kind == 1))) begin
            need = 2; gtag = "R11";
        end
        if (last_v && last_zone != zone) begin
            if (zp[zone] > need) need = zp[zone];
            if (last_post > need) need = last_post;
            if (zp[zone] > 2 || last_post > 2 || gtag == "R10") gtag = "R12";
        end
        exp_idle = (need - last_hold > 1) ? need - last_hold : 1;
        @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_zone = ZW'(zone); req_addr = addr;
        req_len = LW'(len); req_wdata = wd; req_be = be;
        idles = 0;
        forever begin
            #1;
            idles++;
            check_rv();
            pend_rv = 0;
            chk("R10", "idle quiet", {bus_sel, bus_rd, bus_we, bus_doe}, 0);
            if (req_ready || idles > 20) break;
            @(negedge clk);
        end
        chk(gtag, "idle cycles", idles, exp_idle);
        @(posedge clk);
        #1 req_valid = 1'b0;
        wtag = wr && len != 0;
        a = addr;
        if (kind == 1) phase(P_FAST, 0, 0, zone, a, wd, be, "R4");
        else begin
            phase(P_ADDR, wr, ze[zone], zone, a, wd, be, wtag ? "R13" : "R1");
            for (int i = 0; i < zw[zone]; i++)
                phase(P_WAIT, wr, ze[zone], zone, a, wd, be, wtag ? "R13" : "R6");
            phase(P_DATA, wr, ze[zone], zone, a, wd, be, wr ? (wtag ? "R13" : "R3") : "R2");
        end
        if (!wr) begin
            for (int b = 0; b < len; b++) begin
                a = a + 1'b1;
                if (zb[zone]) phase(P_BWAIT, 0, 0, zone, a, wd, be, "R8");
                phase(P_BDATA, 0, 0, zone, a, wd, be, "R7");
            end
        end
        if (kind == 3) phase(P_TRAIL, 1, 1, zone, a, wd, be, wtag ? "R13" : "R5");
        for (int i = 0; i < zh[zone]; i++)
            phase(P_HOLD, wr, ze[zone], zone, a, wd, be, wtag ? "R13" : "R9");
        last_v = 1; last_kind = kind; last_zone = zone;
        last_post = zq[zone]; last_hold = zh[zone];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        set_zone(0, 0, 0, 0, 0, 0, 0, 0);
        set_zone(1, 2, 1, 3, 2, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R10", "reset quiet", {bus_sel, bus_rd, bus_we, bus_doe, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", req_ready, 1);
        // directed corners
        do_txn(0, 0, 16'h0100, 0, 16'h0, 2'b11);      // plain read
        do_txn(1, 0, 16'h0200, 0, 16'hBEEF, 2'b01);   // late write
        do_txn(0, 0, 16'h0300, 3, 16'h0, 2'b11);      // burst, no burst wait
        do_txn(1, 1, 16'h0400, 2, 16'hCAFE, 2'b10);   // early write, len ignored
        do_txn(0, 1, 16'h0500, 0, 16'h0, 2'b11);      // early write -> fast read
        do_txn(0, 1, 16'h0600, 2, 16'h0, 2'b11);      // fast burst with burst wait
        do_txn(1, 0, 16'h0700, 0, 16'h1234, 2'b11);   // zone change
        do_txn(0, 1, 16'h0800, 0, 16'h0, 2'b11);      // late write -> fast read, zone change
        set_zone(0, 0, 0, 0, 0, 0, 0, 0);
        set_zone(1, 0, 0, 0, 0, 0, 1, 0);
        do_txn(1, 1, 16'h0900, 0, 16'h5555, 2'b11);
        do_txn(0, 1, 16'h0A00, 0, 16'h0, 2'b11);      // early write -> normal read, no hold
        for (int n = 0; n < 240; n++) begin
            if (n % 40 == 0) begin
                for (int z = 0; z < NZ; z++)
                    set_zone(z, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8,
                             1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            end
            do_txn(1'($urandom % 2), $urandom % NZ, AW'($urandom), $urandom % 4,
                   DW'($urandom), BEW'(($urandom % 3) + 1));
        end
        @(negedge clk);
        check_rv();
        summary();
    end
endmodule